// File: doc/BRIEF.md
# 128b/130b Transmit Gearbox

This block sits on the transmit side of a 32-bit serial link datapath. Each 130-bit block reaches it over four valid cycles. The first cycle carries a 2-bit sync header and the first 32 payload bits. The next three cycles carry 32 payload bits each. The gearbox repacks this into a 32-bit word stream with no holes in it. Because each block brings two more bits than its four output words can carry, the surplus builds up in a residue buffer.

After sixteen blocks the residue holds exactly one word. The upstream source then leaves one idle cycle, and the gearbox uses that cycle to send the backlog. Bits leave LSB-first. Bit 0 of an output word is the earliest bit on the line.

The block checks the framing it receives. An idle cycle with the wrong backlog, a block start in the wrong place, or a missing block start is flagged. The block then drops its state and restarts framing on the next block start.

Top module: `blk130_tx_gearbox`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after release until the first accepted block start, `out_vld` and `out_err` are 0.
- R2: The line bit order for a block is: pending residue bits first, then `in_hdr[0]`, `in_hdr[1]`, then `in_data[0]` up to `in_data[31]`. On a block-start cycle, `out_data` is the first 32 of these bits, with bit 0 the earliest.
- R3: On each of the three non-start cycles of a block, `out_data` is the pending residue followed by the low bits of `in_data`. The top bits of `in_data` that do not fit become the new residue.
- R4: The residue grows by 2 bits per block. After 16 blocks it holds 32 bits. A single idle cycle (`in_vld` low) at that point outputs those 32 bits as a valid word and empties the residue.
- R5: `in_hdr` is ignored on cycles where `in_start` is low.
- R6: Outputs are registered with one cycle of latency. `out_vld` is 1 exactly after an accepted input word or a backlog drain.
- R7: An idle cycle while framing is held and the residue is not 32 bits gives a one-cycle `out_err` pulse with `out_vld` low.
- R8: The following each give an `out_err` pulse: a start on a word other than the first of a block, a non-start word where a block must begin, and a start while the 32-bit backlog is still undrained.
- R9: After an error, valid words are dropped until the next block start. That start opens a fresh block with an empty residue.
- R10: After reset, valid words without a block start are dropped without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 32 | Payload word |
| in_hdr | input | 2 | Sync header, used only with `in_start` |
| in_start | input | 1 | Marks the first word of a block |
| in_vld | input | 1 | Input word valid; low for the drain gap |
| out_data | output | 32 | Line word, bit 0 earliest |
| out_vld | output | 1 | Output word valid |
| out_err | output | 1 | One-cycle framing error pulse |

## Verification
The first input patterns use all-ones, all-zeros, alternating and mixed words. This makes a wrong shift amount or a swapped header bit show up directly at a known bit position. A header value on a non-start word that differs from the residue shows whether `in_hdr` leaks through.

A run of sixteen blocks followed by the gap is compared against a bit-queue model. This tells a correct backlog drain apart from a residue that is dropped, doubled or off by one block.

Three further cases show that each error kind is detected and that recovery starts from an empty residue: a misplaced start, a missing start, and a start over a full backlog.

// File: rtl/blk130_pkg.sv
// Package: shared sizing for the 128b/130b transmit gearbox.
// Assumes a header width that divides the word width evenly.
package blk130_pkg;
    localparam int unsigned WORD_W        = 32;
    localparam int unsigned HDR_W         = 2;
    localparam int unsigned WORDS_PER_BLK = 4;
endpackage

// File: rtl/blk130_frame_track.sv
// Module: blk130_frame_track
// Follows the block framing of the input stream. It tracks the word position
// inside a block and the number of blocks since the last drain. Every cycle it
// decides whether to accept the word, drain the backlog, or flag an error.
// Assumes the source idles for exactly one cycle after each full backlog.
module blk130_frame_track #(
    parameter int unsigned WORD_W        = blk130_pkg::WORD_W,
    parameter int unsigned HDR_W         = blk130_pkg::HDR_W,
    parameter int unsigned WORDS_PER_BLK = blk130_pkg::WORDS_PER_BLK,
    localparam int unsigned BACKLOG_BLKS = WORD_W / HDR_W,
    localparam int unsigned POS_W        = (WORDS_PER_BLK > 1) ? $clog2(WORDS_PER_BLK) : 1,
    localparam int unsigned BLK_W        = $clog2(BACKLOG_BLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_start,
    output logic             take_o,
    output logic             take_hdr_o,
    output logic             drain_o,
    output logic             flush_o,
    output logic [BLK_W-1:0] blk_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS_PER_BLK - 1);
    localparam logic [BLK_W-1:0] FULL_BLK = BLK_W'(BACKLOG_BLKS);

    logic             synced;
    logic [POS_W-1:0] wpos;
    logic [BLK_W-1:0] blk;

    // Classify the current cycle as accept, drain, error or drop.
    always_comb begin
        take_o     = 1'b0;
        take_hdr_o = 1'b0;
        drain_o    = 1'b0;
        flush_o    = 1'b0;
        if (synced) begin
            if (in_vld) begin
                if (in_start != (wpos == '0)) begin
                    flush_o = 1'b1;
                end else if (in_start && (blk == FULL_BLK)) begin
                    flush_o = 1'b1;
                end else begin
                    take_o     = 1'b1;
                    take_hdr_o = in_start;
                end
            end else if ((blk == FULL_BLK) && (wpos == '0)) begin
                drain_o = 1'b1;
            end else begin
                flush_o = 1'b1;
            end
        end else if (in_vld && in_start) begin
            take_o     = 1'b1;
            take_hdr_o = 1'b1;
        end
    end

    // Advance the word position and the block count, or drop framing on an error.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_o) begin
            synced <= 1'b0;
            wpos   <= '0;
            blk    <= '0;
        end else if (take_o) begin
            synced <= 1'b1;
            wpos   <= (wpos == LAST_POS) ? '0 : wpos + 1'b1;
            if (take_hdr_o) begin
                blk <= blk + 1'b1;
            end
        end else if (drain_o) begin
            blk <= '0;
        end
    end

    assign blk_o = blk;

    // A block can only be partway through if the previous cycle carried a word.
    assert_wpos_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && wpos != '0) |-> $past(in_vld));

    // The block count never goes past one full backlog.
    assert_blk_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk <= FULL_BLK);
endmodule

// File: rtl/blk130_residue_buf.sv
// Module: blk130_residue_buf
// Holds the bits that are waiting to go out. Each cycle it joins the pending
// bits with the new header and data, sends the first word, and keeps the rest.
// The output register is here. Assumes the tracker never accepts a header
// while 32 bits are already pending.
module blk130_residue_buf #(
    parameter int unsigned WORD_W = blk130_pkg::WORD_W,
    parameter int unsigned HDR_W  = blk130_pkg::HDR_W,
    localparam int unsigned CNT_W    = $clog2(WORD_W + 1),
    localparam int unsigned STREAM_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              take_hdr,
    input  logic              drain,
    input  logic              flush,
    input  logic [WORD_W-1:0] in_data,
    input  logic [HDR_W-1:0]  in_hdr,
    output logic [WORD_W-1:0] out_data,
    output logic              out_vld,
    output logic [CNT_W-1:0]  rcnt_o
);
    logic [WORD_W-1:0]       resid;
    logic [CNT_W-1:0]        rcnt;
    logic [WORD_W+HDR_W-1:0] fresh;
    logic [STREAM_W-1:0]     stream;

    // Put the new bits after the pending ones; the header comes first when present.
    always_comb begin
        fresh  = take_hdr ? {in_data, in_hdr} : {{HDR_W{1'b0}}, in_data};
        stream = {{(STREAM_W-WORD_W){1'b0}}, resid}
               | ({{(STREAM_W-WORD_W-HDR_W){1'b0}}, fresh} << rcnt);
    end

    // Register the output word and update the pending bits and their count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resid    <= '0;
            rcnt     <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= take || drain;
            if (take) begin
                out_data <= stream[WORD_W-1:0];
                resid    <= stream[STREAM_W-1:WORD_W];
                rcnt     <= rcnt + (take_hdr ? CNT_W'(HDR_W) : '0);
            end else if (drain) begin
                out_data <= resid;
                resid    <= '0;
                rcnt     <= '0;
            end else if (flush) begin
                resid <= '0;
                rcnt  <= '0;
            end
        end
    end

    assign rcnt_o = rcnt;

    // The residue count only steps up by one header width, or clears.
    assert_rcnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rcnt != $past(rcnt)) |-> (rcnt == $past(rcnt) + CNT_W'(HDR_W) || rcnt == '0));

    // The pending bits never exceed one word.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= CNT_W'(WORD_W));
endmodule

// File: rtl/blk130_tx_gearbox.sv
// Module: blk130_tx_gearbox (top)
// 128b/130b transmit gearbox: takes four words per block, the first with a
// sync header, and sends one 32-bit word every valid cycle. The surplus
// header bits are sent on the source's gap cycle after sixteen blocks.
// Framing errors give a one-cycle pulse. Reset is synchronous and active low.
module blk130_tx_gearbox #(
    parameter int unsigned WORD_W        = blk130_pkg::WORD_W,
    parameter int unsigned HDR_W         = blk130_pkg::HDR_W,
    parameter int unsigned WORDS_PER_BLK = blk130_pkg::WORDS_PER_BLK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic              in_start,
    input  logic              in_vld,
    output logic [WORD_W-1:0] out_data,
    output logic              out_vld,
    output logic              out_err
);
    localparam int unsigned BACKLOG_BLKS = WORD_W / HDR_W;
    localparam int unsigned BLK_W        = $clog2(BACKLOG_BLKS + 1);
    localparam int unsigned CNT_W        = $clog2(WORD_W + 1);

    logic             take, take_hdr, drain, flush;
    logic [BLK_W-1:0] blk;
    logic [CNT_W-1:0] rcnt;

    blk130_frame_track #(
        .WORD_W(WORD_W), .HDR_W(HDR_W), .WORDS_PER_BLK(WORDS_PER_BLK)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_start(in_start),
        .take_o(take), .take_hdr_o(take_hdr), .drain_o(drain),
        .flush_o(flush), .blk_o(blk)
    );

    blk130_residue_buf #(
        .WORD_W(WORD_W), .HDR_W(HDR_W)
    ) u_resid (
        .clk(clk), .rst_n(rst_n), .take(take), .take_hdr(take_hdr),
        .drain(drain), .flush(flush), .in_data(in_data), .in_hdr(in_hdr),
        .out_data(out_data), .out_vld(out_vld), .rcnt_o(rcnt)
    );

    // Register the error pulse so it lines up with the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_err <= 1'b0;
        end else begin
            out_err <= flush;
        end
    end

    // The residue size and the tracker's block count must agree.
    assert_resid_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rcnt) == 32'(blk) * HDR_W);

    // A valid output comes only from an input word or a full backlog.
    assert_out_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($past(in_vld) || $past(rcnt) == CNT_W'(WORD_W)));

    // An error cycle never also gives a valid word.
    assert_err_no_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !out_vld);
endmodule

// File: tb/blk130_tx_gearbox_bench.sv
// Bench: walks a table of vectors, then runs directed tests. The directed
// tests use a bit-queue line model for the backlog and the error recovery.
module blk130_tx_gearbox_bench;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        vld;
        logic        start;
        logic [1:0]  hdr;
        logic [31:0] data;
        logic        ev;
        logic [31:0] ed;
        logic        ee;
    } vec_t;

    // The expected fields are checked one cycle after each row is driven.
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 2'b00, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0}, // R10 no start yet
        '{1'b1, 1'b1, 2'b10, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFE, 1'b0}, // R2
        '{1'b1, 1'b0, 2'b11, 32'h00000000, 1'b1, 32'h00000003, 1'b0}, // R3 R5
        '{1'b1, 1'b0, 2'b00, 32'hAAAAAAAA, 1'b1, 32'hAAAAAAA8, 1'b0}, // R3
        '{1'b1, 1'b0, 2'b00, 32'h12345678, 1'b1, 32'h48D159E2, 1'b0}, // R3
        '{1'b1, 1'b1, 2'b01, 32'h00000000, 1'b1, 32'h00000004, 1'b0}, // R2
        '{1'b1, 1'b0, 2'b00, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFF0, 1'b0}, // R3
        '{1'b1, 1'b1, 2'b01, 32'h00000000, 1'b0, 32'h0,        1'b1}, // R8 misplaced
        '{1'b1, 1'b0, 2'b00, 32'hFFFFFFFF, 1'b0, 32'h0,        1'b0}, // R9 dropped
        '{1'b1, 1'b1, 2'b11, 32'h00000000, 1'b1, 32'h00000003, 1'b0}, // R9 fresh
        '{1'b0, 1'b0, 2'b00, 32'h00000000, 1'b0, 32'h0,        1'b1}  // R7 early gap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_hdr = '0;
    logic        in_start = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] out_data;
    logic        out_vld;
    logic        out_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    blk130_tx_gearbox u_blk130_tx_gearbox (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_hdr(in_hdr),
        .in_start(in_start), .in_vld(in_vld), .out_data(out_data),
        .out_vld(out_vld), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs, then wait for the next falling edge to sample.
    task automatic drive(input logic v, input logic s, input logic [1:0] h, input logic [31:0] d);
        in_vld = v; in_start = s; in_hdr = h; in_data = d;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [31:0] ed, input logic ee);
        chk(out_vld === ev, {req, " vld"}, 64'(out_vld), 64'(ev));
        chk(out_err === ee, {req, " err"}, 64'(out_err), 64'(ee));
        if (ev) chk(out_data === ed, {req, " data"}, 64'(out_data), 64'(ed));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        expect_out("R1 in reset", 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        q.delete();
    endtask

    // Send one model-checked word: push its bits to the queue, expect 32 off the front.
    task automatic model_word(input string req, input logic s, input logic [1:0] h, input logic [31:0] d);
        logic [31:0] e;
        if (s) begin q.push_back(h[0]); q.push_back(h[1]); end
        for (int i = 0; i < 32; i++) q.push_back(d[i]);
        for (int i = 0; i < 32; i++) e[i] = q.pop_front();
        drive(1'b1, s, h, d);
        expect_out(req, 1'b1, e, 1'b0);
    endtask

    task automatic model_blocks(input int nb, input int seed);
        for (int b = 0; b < nb; b++)
            for (int w = 0; w < 4; w++)
                model_word("R4 run", w == 0, (b % 2 == 0) ? 2'b01 : 2'b10,
                           32'h9E3779B9 * (seed + b * 4 + w + 1));
    endtask

    initial begin
        logic [31:0] e;
        @(negedge clk);
        do_reset();
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        expect_out("R1 after release", 1'b0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].vld, TBL[i].start, TBL[i].hdr, TBL[i].data);
            expect_out($sformatf("table row %0d", i), TBL[i].ev, TBL[i].ed, TBL[i].ee);
        end

        // R4 R6: sixteen blocks, the drain gap, then one block from an empty residue.
        do_reset();
        model_blocks(16, 0);
        chk(q.size() == 32, "R4 model backlog", 64'(q.size()), 64'd32);
        for (int i = 0; i < 32; i++) e[i] = q.pop_front();
        drive(1'b0, 1'b0, 2'b11, 32'hFFFFFFFF);
        expect_out("R4 drain", 1'b1, e, 1'b0);
        model_blocks(1, 100);
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        expect_out("R7 gap after one block", 1'b0, 32'h0, 1'b1);

        // R8: a start over an undrained backlog, then R9 recovery.
        do_reset();
        model_blocks(16, 7);
        drive(1'b1, 1'b1, 2'b01, 32'h0);
        expect_out("R8 start on full backlog", 1'b0, 32'h0, 1'b1);
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        expect_out("R9 idle while unsynced", 1'b0, 32'h0, 1'b0);
        q.delete();
        model_blocks(1, 33);

        // R8: a missing start where a block must begin.
        drive(1'b1, 1'b0, 2'b10, 32'h55555555);
        expect_out("R8 missing start", 1'b0, 32'h0, 1'b1);
        drive(1'b1, 1'b1, 2'b10, 32'h0000000F);
        expect_out("R9 restart", 1'b1, 32'h0000003E, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule